// File: doc/BRIEF.md
# Destination Address Filter with Station CAM

This block decides whether an incoming frame is meant for this station by looking only at its 48-bit destination address. It keeps sixteen 48-bit station addresses and a 16-bit mask that switches each one into or out of matching. Three mode pins can widen acceptance: promiscuous, all-multicast and broadcast. Each destination handed over on the destination stream produces exactly one result, one cycle later. The result is one of four classes: reject, unicast accept, multicast accept or broadcast accept. The result also carries a 16-bit receive-status fragment with the class bits already in place.

The address table is filled by a load sequencer. Software starts a load by giving a descriptor count and a start pointer. The sequencer then takes a stream of 16-bit descriptor words on a valid/ready interface. `wd_ready` is high for the whole load and low at all other times, so the producer may pause by dropping `wd_valid` but never has to wait on the block while a load runs. The destination interface pushes back the other way: `dst_ready` is low while a load is in progress, so no frame is classified against a half-written table. While the controller is held in reset, software can read any entry back through three 16-bit readback words.

Top module: `addr_filter_cam`

## Requirements
- R1: With `cfg_promisc` set, a destination whose byte 0 bit 0 (`dst_addr[0]`) is clear gives `res_kind` = 1 (unicast accept). Byte n of an address sits at bits [8n+7:8n].
- R2: With `cfg_allmulti` set, a destination with `dst_addr[0]` set gives `res_kind` = 2 (multicast) and sets `res_status[8]`.
- R3: With `cfg_bcast` set, the all-ones destination gives `res_kind` = 3 (broadcast) and sets `res_status[7]`.
- R4: A destination equal to a table entry whose mask bit is set gives `res_kind` = 1. An entry whose mask bit is clear never matches. Anything not accepted gives `res_kind` = 0. Unicast and reject leave `res_status` all zero.
- R5: When several rules apply, the first one wins, in this order: promiscuous, all-multicast, broadcast, table match.
- R6: A descriptor is 4 logical words. Word 0 is ignored. Words 1, 2 and 3 carry address bytes {1,0}, {3,2} and {5,4}, with the lower-numbered byte in bits [7:0].
- R7: A load writes `load_count[4:0]` entries into indices 0, 1, 2 and so on; the upper count bits are ignored. `desc_ptr` starts at `load_ptr` and advances by one descriptor stride per entry: 8 in narrow mode, 16 in wide mode. A count of zero loads only the mask.
- R8: After the entries, one more descriptor follows. Its word 0 becomes the enable mask. `load_busy` then drops, and `load_done` pulses high for exactly one cycle in that same cycle.
- R9: With `wide_mode` set at load start, each logical word takes two stream words, and only the first (lower) one of each pair is used, giving 8 stream words per descriptor.
- R10: `rb_word0`, `rb_word1` and `rb_word2` return bytes {1,0}, {3,2} and {5,4} of the entry selected by `rb_sel` when `ctrl_in_reset` is high, and read zero otherwise.
- R11: A destination accepted (valid and ready) at a clock edge gives `res_valid` high for the following cycle only. `dst_ready` is low and `wd_ready` high exactly while `load_busy` is high.
- R12: After reset: no load is running, the table and mask are all zero, `res_valid` is low and `desc_ptr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_in_reset | input | 1 | Controller is in its reset state; enables readback |
| wide_mode | input | 1 | 32-bit data mode, sampled at load start |
| cfg_promisc | input | 1 | Promiscuous acceptance |
| cfg_allmulti | input | 1 | Accept all multicast |
| cfg_bcast | input | 1 | Accept broadcast |
| load_start | input | 1 | Start a table load (ignored while busy) |
| load_count | input | 16 | Descriptor count register; low 5 bits used |
| load_ptr | input | 16 | Starting descriptor pointer |
| desc_ptr | output | 16 | Current descriptor pointer |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | One-cycle load-complete pulse |
| wd_valid | input | 1 | Descriptor word valid |
| wd_ready | output | 1 | Descriptor word accepted |
| wd_data | input | 16 | Descriptor word |
| dst_valid | input | 1 | Destination valid |
| dst_ready | output | 1 | Destination can be accepted |
| dst_addr | input | 48 | Destination address, byte 0 in bits [7:0] |
| res_valid | output | 1 | Classification result strobe |
| res_kind | output | 2 | 0 reject, 1 unicast, 2 multicast, 3 broadcast |
| res_status | output | 16 | Status fragment: bit 8 multicast, bit 7 broadcast |
| rb_sel | input | 4 | Readback entry select |
| rb_word0 | output | 16 | Entry bytes {1,0} |
| rb_word1 | output | 16 | Entry bytes {3,2} |
| rb_word2 | output | 16 | Entry bytes {5,4} |

## Verification
The properties on classification assume the three mode pins hold steady from the cycle a destination is accepted through the cycle its result appears. The bench changes modes only between classifications. The properties also assume `wide_mode` and `load_count` are settled when `load_start` is sampled and that `load_start` is a single-cycle pulse given only while idle; the bench drives every load that way. Descriptor words are offered only while a load runs, with idle gaps inserted, and destinations are offered during a load only to confirm they are held off.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef enum logic [1:0] {
    CLS_REJECT  = 2'd0,
    CLS_UNICAST = 2'd1,
    CLS_MULTI   = 2'd2,
    CLS_BCAST   = 2'd3
  } afc_class_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ENTRY = 2'd1,
    SEQ_MASK  = 2'd2
  } afc_seq_e;

  localparam int STAT_MC_BIT = 8;
  localparam int STAT_BC_BIT = 7;
  localparam int DESC_WORDS  = 4;
endpackage

// File: rtl/afc_load_seq.sv
module afc_load_seq #(
  parameter int N    = 16,
  parameter int WW   = 16,
  parameter int CNTW = 5,
  parameter int PW   = 16,
  parameter int IDXW = $clog2(N),
  parameter int PIW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CNTW-1:0] count_in,
  input  logic [PW-1:0]   ptr_in,
  input  logic            wide,
  input  logic            wd_valid,
  input  logic [WW-1:0]   wd_data,
  output logic            wd_ready,
  output logic            busy,
  output logic            done,
  output logic [PW-1:0]   desc_ptr,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [PIW-1:0]  wr_part,
  output logic [WW-1:0]   wr_data,
  output logic            mask_we,
  output logic [N-1:0]    mask_data
);
  import afc_pkg::*;

  localparam int SLOT_W     = $clog2(2 * DESC_WORDS);
  localparam int DESC_BYTES = DESC_WORDS * WW / 8;

  afc_seq_e          state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CNTW-1:0]   cnt_q;
  logic [IDXW-1:0]   idx_q;
  logic [PW-1:0]     ptr_q;
  logic              wide_q;
  logic              done_q;

  logic [1:0] lword;
  logic       lower_slot;
  logic       last_slot;
  logic       fire;

  always_comb begin
    lword      = wide_q ? slot_q[2:1] : slot_q[1:0];
    lower_slot = !wide_q || !slot_q[0];
    last_slot  = wide_q ? (slot_q == SLOT_W'(2 * DESC_WORDS - 1))
                        : (slot_q == SLOT_W'(DESC_WORDS - 1));
  end

  assign wd_ready  = (state_q != SEQ_IDLE);
  assign busy      = (state_q != SEQ_IDLE);
  assign fire      = wd_valid && wd_ready;
  assign done      = done_q;
  assign desc_ptr  = ptr_q;

  assign wr_en     = fire && (state_q == SEQ_ENTRY) && lower_slot && (lword != 2'd0);
  assign wr_idx    = idx_q;
  assign wr_part   = PIW'(lword - 2'd1);
  assign wr_data   = wd_data;
  assign mask_we   = fire && (state_q == SEQ_MASK) && lower_slot && (lword == 2'd0);
  assign mask_data = N'(wd_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      slot_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      ptr_q   <= '0;
      wide_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            cnt_q   <= count_in;
            ptr_q   <= ptr_in;
            wide_q  <= wide;
            idx_q   <= '0;
            slot_q  <= '0;
            state_q <= (count_in != '0) ? SEQ_ENTRY : SEQ_MASK;
          end
        end
        SEQ_ENTRY: begin
          if (fire) begin
            if (last_slot) begin
              slot_q <= '0;
              cnt_q  <= cnt_q - 1'b1;
              idx_q  <= idx_q + 1'b1;
              ptr_q  <= ptr_q + (wide_q ? PW'(2 * DESC_BYTES) : PW'(DESC_BYTES));
              if (cnt_q == CNTW'(1)) state_q <= SEQ_MASK;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
        end
        SEQ_MASK: begin
          if (fire) begin
            if (last_slot) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/afc_cam_store.sv
module afc_cam_store #(
  parameter int N    = 16,
  parameter int AW   = 48,
  parameter int WW   = 16,
  parameter int IDXW = $clog2(N),
  parameter int PIW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [PIW-1:0]  wr_part,
  input  logic [WW-1:0]   wr_data,
  input  logic            mask_we,
  input  logic [N-1:0]    mask_data,
  input  logic [AW-1:0]   probe,
  input  logic [IDXW-1:0] rb_idx,
  output logic [N-1:0]    hit_vec,
  output logic [AW-1:0]   rb_entry
);
  localparam int PARTS = AW / WW;

  logic [WW-1:0] part_q [N][PARTS];
  logic [AW-1:0] entry  [N];
  logic [N-1:0]  en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (mask_we) en_q <= mask_data;
  end

  for (genvar e = 0; e < N; e++) begin : g_entry
    for (genvar p = 0; p < PARTS; p++) begin : g_part
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) part_q[e][p] <= '0;
        else if (wr_en && wr_idx == IDXW'(e) && wr_part == PIW'(p))
          part_q[e][p] <= wr_data;
      end
      assign entry[e][p*WW +: WW] = part_q[e][p];
    end
    assign hit_vec[e] = en_q[e] && (entry[e] == probe);
  end

  assign rb_entry = entry[rb_idx];
endmodule

// File: rtl/afc_classifier.sv
module afc_classifier #(
  parameter int N  = 16,
  parameter int AW = 48
) (
  input  logic                promisc,
  input  logic                allmulti,
  input  logic                bcast_en,
  input  logic [AW-1:0]       addr,
  input  logic [N-1:0]        hit_vec,
  output afc_pkg::afc_class_e kind
);
  import afc_pkg::*;

  logic group_bit;
  logic all_ones;

  assign group_bit = addr[0];
  assign all_ones  = &addr;

  always_comb begin
    if (promisc && !group_bit)       kind = CLS_UNICAST;
    else if (allmulti && group_bit)  kind = CLS_MULTI;
    else if (bcast_en && all_ones)   kind = CLS_BCAST;
    else if (|hit_vec)               kind = CLS_UNICAST;
    else                             kind = CLS_REJECT;
  end
endmodule

// File: rtl/addr_filter_cam.sv
module addr_filter_cam #(
  parameter int N    = 16,
  parameter int AW   = 48,
  parameter int WW   = 16,
  parameter int CNTW = 5,
  parameter int PW   = 16,
  localparam int IDXW = $clog2(N),
  localparam int PIW  = $clog2(AW / WW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_in_reset,
  input  logic            wide_mode,
  input  logic            cfg_promisc,
  input  logic            cfg_allmulti,
  input  logic            cfg_bcast,
  input  logic            load_start,
  input  logic [WW-1:0]   load_count,
  input  logic [PW-1:0]   load_ptr,
  output logic [PW-1:0]   desc_ptr,
  output logic            load_busy,
  output logic            load_done,
  input  logic            wd_valid,
  output logic            wd_ready,
  input  logic [WW-1:0]   wd_data,
  input  logic            dst_valid,
  output logic            dst_ready,
  input  logic [AW-1:0]   dst_addr,
  output logic            res_valid,
  output logic [1:0]      res_kind,
  output logic [WW-1:0]   res_status,
  input  logic [IDXW-1:0] rb_sel,
  output logic [WW-1:0]   rb_word0,
  output logic [WW-1:0]   rb_word1,
  output logic [WW-1:0]   rb_word2
);
  import afc_pkg::*;

  localparam int PARTS = AW / WW;

  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [PIW-1:0]  wr_part;
  logic [WW-1:0]   wr_data;
  logic            mask_we;
  logic [N-1:0]    mask_data;
  logic [N-1:0]    hit_vec;
  logic [AW-1:0]   rb_entry;
  logic [AW-1:0]   dst_q;
  logic            pend_q;
  afc_class_e      kind;
  logic [WW-1:0]   rb_part [PARTS];
  logic            unused_cnt_hi;

  assign unused_cnt_hi = ^load_count[WW-1:CNTW];

  afc_load_seq #(.N(N), .WW(WW), .CNTW(CNTW), .PW(PW), .IDXW(IDXW), .PIW(PIW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (load_start),
    .count_in  (load_count[CNTW-1:0]),
    .ptr_in    (load_ptr),
    .wide      (wide_mode),
    .wd_valid  (wd_valid),
    .wd_data   (wd_data),
    .wd_ready  (wd_ready),
    .busy      (load_busy),
    .done      (load_done),
    .desc_ptr  (desc_ptr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_part   (wr_part),
    .wr_data   (wr_data),
    .mask_we   (mask_we),
    .mask_data (mask_data)
  );

  afc_cam_store #(.N(N), .AW(AW), .WW(WW), .IDXW(IDXW), .PIW(PIW)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_part   (wr_part),
    .wr_data   (wr_data),
    .mask_we   (mask_we),
    .mask_data (mask_data),
    .probe     (dst_q),
    .rb_idx    (rb_sel),
    .hit_vec   (hit_vec),
    .rb_entry  (rb_entry)
  );

  afc_classifier #(.N(N), .AW(AW)) u_cls (
    .promisc  (cfg_promisc),
    .allmulti (cfg_allmulti),
    .bcast_en (cfg_bcast),
    .addr     (dst_q),
    .hit_vec  (hit_vec),
    .kind     (kind)
  );

  assign dst_ready = !load_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= dst_valid && dst_ready;
      if (dst_valid && dst_ready) dst_q <= dst_addr;
    end
  end

  assign res_valid = pend_q;
  assign res_kind  = kind;

  always_comb begin
    res_status = '0;
    res_status[STAT_MC_BIT] = (kind == CLS_MULTI);
    res_status[STAT_BC_BIT] = (kind == CLS_BCAST);
  end

  for (genvar p = 0; p < PARTS; p++) begin : g_rb
    assign rb_part[p] = ctrl_in_reset ? rb_entry[p*WW +: WW] : '0;
  end

  assign rb_word0 = rb_part[0];
  assign rb_word1 = rb_part[1];
  assign rb_word2 = rb_part[2];
endmodule

// File: rtl/afc_checker.sv
module afc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_in_reset,
  input logic        cfg_promisc,
  input logic        cfg_allmulti,
  input logic        load_busy,
  input logic        load_done,
  input logic        wd_ready,
  input logic        dst_valid,
  input logic        dst_ready,
  input logic [47:0] dst_addr,
  input logic        res_valid,
  input logic [1:0]  res_kind,
  input logic [15:0] res_status,
  input logic [15:0] rb_word0,
  input logic [15:0] rb_word1,
  input logic [15:0] rb_word2
);
  p_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_ready) |=> res_valid);

  p_no_stray_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dst_valid && dst_ready) |=> !res_valid);

  p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy |-> !dst_ready);

  p_words_only_loading_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load_busy |-> !wd_ready);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  p_done_on_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_busy) |-> load_done);

  p_rb_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_in_reset |-> (rb_word0 == 16'h0 && rb_word1 == 16'h0 && rb_word2 == 16'h0));

  p_promisc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_ready && cfg_promisc && !dst_addr[0]) |=> (res_kind == 2'd1));

  p_allmulti_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_ready && !cfg_promisc && cfg_allmulti && dst_addr[0])
      |=> (res_kind == 2'd2 && res_status[8]));
endmodule

bind addr_filter_cam afc_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctrl_in_reset (ctrl_in_reset),
  .cfg_promisc   (cfg_promisc),
  .cfg_allmulti  (cfg_allmulti),
  .load_busy     (load_busy),
  .load_done     (load_done),
  .wd_ready      (wd_ready),
  .dst_valid     (dst_valid),
  .dst_ready     (dst_ready),
  .dst_addr      (dst_addr),
  .res_valid     (res_valid),
  .res_kind      (res_kind),
  .res_status    (res_status),
  .rb_word0      (rb_word0),
  .rb_word1      (rb_word1),
  .rb_word2      (rb_word2)
);

// File: tb/addr_filter_cam_tb_top.sv
module addr_filter_cam_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_in_reset;
  logic        wide_mode;
  logic        cfg_promisc, cfg_allmulti, cfg_bcast;
  logic        load_start;
  logic [15:0] load_count, load_ptr, desc_ptr;
  logic        load_busy, load_done;
  logic        wd_valid, wd_ready;
  logic [15:0] wd_data;
  logic        dst_valid, dst_ready;
  logic [47:0] dst_addr;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic [15:0] res_status;
  logic [3:0]  rb_sel;
  logic [15:0] rb_word0, rb_word1, rb_word2;

  int total = 0;
  int bad   = 0;

  logic [47:0] m_cam [16];
  logic [15:0] m_mask;
  logic [47:0] pat_a [16];
  logic [47:0] pat_b [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_filter_cam dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_in_reset(ctrl_in_reset), .wide_mode(wide_mode),
    .cfg_promisc(cfg_promisc), .cfg_allmulti(cfg_allmulti), .cfg_bcast(cfg_bcast),
    .load_start(load_start), .load_count(load_count), .load_ptr(load_ptr),
    .desc_ptr(desc_ptr), .load_busy(load_busy), .load_done(load_done),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_addr(dst_addr),
    .res_valid(res_valid), .res_kind(res_kind), .res_status(res_status),
    .rb_sel(rb_sel), .rb_word0(rb_word0), .rb_word1(rb_word1), .rb_word2(rb_word2)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_kind(input logic [47:0] a);
    if (cfg_promisc && !a[0]) return 2'd1;
    if (cfg_allmulti && a[0]) return 2'd2;
    if (cfg_bcast && (&a)) return 2'd3;
    for (int e = 0; e < 16; e++)
      if (m_mask[e] && m_cam[e] == a) return 2'd1;
    return 2'd0;
  endfunction

  function automatic string rule_tag(input logic [47:0] a);
    int n = 0;
    bit hit = 0;
    for (int e = 0; e < 16; e++)
      if (m_mask[e] && m_cam[e] == a) hit = 1;
    n = int'(cfg_promisc && !a[0]) + int'(cfg_allmulti && a[0]) + int'(cfg_bcast && (&a)) + int'(hit);
    if (n > 1) return "R5";
    if (cfg_promisc && !a[0]) return "R1";
    if (cfg_allmulti && a[0]) return "R2";
    if (cfg_bcast && (&a)) return "R3";
    return "R4";
  endfunction

  task automatic classify(input logic [47:0] a);
    logic [1:0]  ek;
    logic [15:0] es;
    string       tg;
    ek = exp_kind(a);
    tg = rule_tag(a);
    es = (ek == 2'd2) ? 16'h0100 : (ek == 2'd3) ? 16'h0080 : 16'h0000;
    dst_valid = 1'b1;
    dst_addr  = a;
    @(negedge clk);
    dst_valid = 1'b0;
    check("R11 result strobe", 64'(res_valid), 64'(1));
    check({tg, " class"}, 64'(res_kind), 64'(ek));
    check({tg, " status"}, 64'(res_status), 64'(es));
    @(negedge clk);
    check("R11 strobe one cycle", 64'(res_valid), 64'(0));
  endtask

  task automatic push_word(input logic [15:0] w, input bit gap);
    if (gap) begin
      wd_valid = 1'b0;
      @(negedge clk);
    end
    wd_valid = 1'b1;
    wd_data  = w;
    @(negedge clk);
    wd_valid = 1'b0;
  endtask

  task automatic push_logical(input logic [15:0] w, input bit wide, input bit gap);
    push_word(w, gap);
    if (wide) push_word(16'hFFFF, 1'b0);
  endtask

  task automatic run_load(input logic [15:0] cnt, input logic [15:0] ptr, input bit wide,
                          input logic [47:0] src [16], input logic [15:0] mask, input bit probe_hold);
    int n;
    n = int'(cnt[4:0]);
    wide_mode  = wide;
    load_count = cnt;
    load_ptr   = ptr;
    load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    check("R8 busy during load", 64'(load_busy), 64'(1));
    check("R11 dst held off", 64'(dst_ready), 64'(0));
    check("R11 words accepted", 64'(wd_ready), 64'(1));
    if (probe_hold) begin
      dst_valid = 1'b1;
      dst_addr  = 48'hFFFF_FFFF_FFFF;
      @(negedge clk);
      dst_valid = 1'b0;
      check("R11 no result while loading", 64'(res_valid), 64'(0));
    end
    for (int k = 0; k < n; k++) begin
      push_logical(16'hDEAD, wide, (k % 3) == 1);
      push_logical(src[k][15:0],  wide, 1'b0);
      push_logical(src[k][31:16], wide, (k % 2) == 0);
      push_logical(src[k][47:32], wide, 1'b0);
      m_cam[k % 16] = src[k];
    end
    push_logical(mask, wide, 1'b1);
    push_logical(16'h1357, wide, 1'b0);
    push_logical(16'h2468, wide, 1'b0);
    push_logical(16'hACE1, wide, 1'b0);
    m_mask = mask;
    check("R8 done pulse", 64'(load_done), 64'(1));
    check("R8 busy cleared", 64'(load_busy), 64'(0));
    check("R7 pointer advance", 64'(desc_ptr), 64'(16'(ptr + n * (wide ? 16 : 8))));
    @(negedge clk);
    check("R8 done single cycle", 64'(load_done), 64'(0));
  endtask

  task automatic readback_all(input string tag);
    ctrl_in_reset = 1'b1;
    for (int e = 0; e < 16; e++) begin
      rb_sel = 4'(e);
      #1;
      check({tag, " readback word0"}, 64'(rb_word0), 64'(m_cam[e][15:0]));
      check({tag, " readback word1"}, 64'(rb_word1), 64'(m_cam[e][31:16]));
      check({tag, " readback word2"}, 64'(rb_word2), 64'(m_cam[e][47:32]));
    end
    ctrl_in_reset = 1'b0;
    for (int e = 0; e < 16; e++) begin
      rb_sel = 4'(e);
      #1;
      check("R10 readback gated", 64'({rb_word2, rb_word1, rb_word0}), 64'(0));
    end
  endtask

  task automatic sweep();
    for (int m = 0; m < 8; m++) begin
      cfg_promisc  = m[0];
      cfg_allmulti = m[1];
      cfg_bcast    = m[2];
      for (int e = 0; e < 16; e++) begin
        classify(m_cam[e]);
        classify(m_cam[e] ^ (48'h1 << 40));
      end
      classify(48'hFFFF_FFFF_FFFF);
      classify(48'h5E00_0000_3301);
      classify(48'h1234_5678_9A00);
      classify(48'hFFFF_FFFF_FFFE);
    end
    cfg_promisc = 0; cfg_allmulti = 0; cfg_bcast = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      pat_a[i] = {8'(8'h60 + i), 8'(8'h50 ^ i), 8'(8'h40 + 3 * i), 8'h30, 8'(8'h20 + i), 8'(8'h02 + 2 * i)};
      pat_b[i] = {8'h7A, 8'(8'hC0 + i), 8'h11, 8'(8'h90 + 5 * i), 8'h33, 8'(8'h41 + 2 * i)};
      m_cam[i] = '0;
    end
    m_mask = '0;
    rst_n = 0; ctrl_in_reset = 1; wide_mode = 0;
    cfg_promisc = 0; cfg_allmulti = 0; cfg_bcast = 0;
    load_start = 0; load_count = 0; load_ptr = 0;
    wd_valid = 0; wd_data = 0; dst_valid = 0; dst_addr = 0; rb_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    check("R12 idle after reset", 64'(load_busy), 64'(0));
    check("R12 no result after reset", 64'(res_valid), 64'(0));
    check("R12 pointer after reset", 64'(desc_ptr), 64'(0));
    check("R11 dst ready when idle", 64'(dst_ready), 64'(1));
    check("R11 words refused when idle", 64'(wd_ready), 64'(0));
    readback_all("R12");
    classify(48'h0000_0000_0000);

    // R6 R7: narrow load of all 16 entries, some disabled
    run_load(16'd16, 16'h0100, 1'b0, pat_a, 16'hF0F5, 1'b1);
    readback_all("R6");
    sweep();

    // R9 R7: wide load, upper count bits ignored, 3 entries; others retained
    run_load(16'hFFE3, 16'h2000, 1'b1, pat_b, 16'h000F, 1'b0);
    readback_all("R9");
    sweep();

    // R7 R8: zero count loads the mask only
    run_load(16'h0020, 16'h3000, 1'b0, pat_a, 16'h8001, 1'b0);
    readback_all("R7");
    sweep();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule